// File: doc/BRIEF.md
# Phase-Shiftable Three-Pair Complementary PWM Generator

The block drives three complementary output pairs from one shared period counter. In edge-aligned mode the counter climbs from zero to one below a programmable modulus and wraps. In center-aligned mode it climbs to the modulus and then descends to zero. Six compare values, two per pair, place the switching edges. A per-pair asymmetric bit lets the two values of a pair set a phase-shifted pulse. In center mode the pair uses one value on the rising slope and the other on the falling slope. In edge mode the two compare results are combined by exclusive-or, so one value starts the pulse and the other ends it.

The selected raw signal of each pair goes through complementary generation and deadtime insertion. A one-clock reload pulse marks every return of the counter to zero, so another block can use it to time sampling. The modulus, the six values, the asymmetric bits and the mode are held in working copies. These copies are refreshed only at the reload point, or continuously while the generator is stopped. Software may write new settings at any time without tearing the current period.

Top module: `pwm_phase_gen`

## Requirements
- R1: While `rst_n` is low, all six outputs and `reload_out` are low.
- R2: While `run` is low, all outputs and `reload_out` are low, and the counter is held at zero counting up. When `run` rises, the first period starts without a reload pulse.
- R3: In edge mode (`center_in`=0) with modulus M, the counter runs 0,1,…,M-1 and then returns to 0, so one period is M clocks. `reload_out` is high for exactly the one clock in which the counter has just returned to 0.
- R4: In center mode (`center_in`=1) with modulus M, the counter runs 0 up to M and then down to 1 before returning to 0, so one period is 2M clocks. It counts as "up" for the values 0..M-1 and as "down" from M to 1. `reload_out` behaves as in R3.
- R5: With a pair's asymmetric bit clear, in either mode, the raw signal of pair p is high while the counter is greater than or equal to value 2p.
- R6: In center mode with asymmetric bit p set, pair p compares against value 2p while counting up and against value 2p+1 while counting down. Each compare uses the rule "counter ≥ value".
- R7: In edge mode with asymmetric bit p set, the raw signal of pair p is (counter ≥ value 2p) XOR (counter ≥ value 2p+1).
- R8: Output 2p follows the raw signal of pair p and output 2p+1 follows its inverse, one clock after the counter value that produced it. The two outputs of a pair are never high together.
- R9: Each time a pair's raw signal changes, both outputs of that pair stay low for `dead_in` clocks. The count restarts if the raw signal changes again inside the gap. A value of 0 gives no gap.
- R10: Changes to `mod_in`, `val_in`, `asym_in` and `center_in` while running take effect only from the next return of the counter to 0. The change of `dead_in` applies to the next raw change.
- R11: Value k occupies bits [CW*(k+1)-1 : CW*k] of `val_in`. Bit p of `asym_in` belongs to pair p. Pair p drives outputs 2p and 2p+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter and outputs enabled |
| center_in | input | 1 | 1 = center-aligned, 0 = edge-aligned |
| asym_in | input | NP | Per-pair asymmetric enable |
| mod_in | input | CW | Period modulus M (2 or more) |
| val_in | input | 2*NP*CW | Six packed compare values |
| dead_in | input | DW | Deadtime length in clocks |
| pwm_out | output | 2*NP | Complementary outputs, even = active, odd = inverse |
| reload_out | output | 1 | One-clock pulse at each period start |

## Verification
The reload point and a compare edge can fall in the same cycle. A compare value of 0 makes a raw edge coincide with the counter's return to zero. New values written in the middle of a period also land exactly on that cycle. The bench provokes both cases, with deadtime active and with asymmetric pairs. A behavioural model computes the counter from a period position. That model decides in the same cycle whether the old or the new copy of the settings applies, and it compares the outputs and the reload pulse on every clock.

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen #(
  parameter int CW = 12,
  parameter int DW = 4,
  parameter int NP = 3,
  localparam int NC = 2 * NP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             center_in,
  input  logic [NP-1:0]    asym_in,
  input  logic [CW-1:0]    mod_in,
  input  logic [NC*CW-1:0] val_in,
  input  logic [DW-1:0]    dead_in,
  output logic [NC-1:0]    pwm_out,
  output logic             reload_out
);

  logic [CW-1:0]    cnt;
  logic             up;
  logic [CW-1:0]    act_mod;
  logic [NC*CW-1:0] act_val;
  logic [NP-1:0]    act_asym;
  logic             act_ctr;
  logic             run_q;
  logic             reload_q;
  logic [NP-1:0]    raw_c, raw_q;

  logic [CW:0] cnt_inc;
  logic        top_hit, wrap;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign top_hit = cnt_inc >= {1'b0, act_mod};
  assign wrap    = act_ctr ? (!up && cnt <= CW'(1)) : top_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      up       <= 1'b1;
      act_mod  <= '0;
      act_val  <= '0;
      act_asym <= '0;
      act_ctr  <= 1'b0;
      run_q    <= 1'b0;
      reload_q <= 1'b0;
    end else if (!run) begin
      cnt      <= '0;
      up       <= 1'b1;
      act_mod  <= mod_in;
      act_val  <= val_in;
      act_asym <= asym_in;
      act_ctr  <= center_in;
      run_q    <= 1'b0;
      reload_q <= 1'b0;
    end else begin
      run_q    <= 1'b1;
      reload_q <= wrap;
      if (wrap) begin
        cnt      <= '0;
        up       <= 1'b1;
        act_mod  <= mod_in;
        act_val  <= val_in;
        act_asym <= asym_in;
        act_ctr  <= center_in;
      end else if (act_ctr && !up) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= cnt_inc[CW-1:0];
        up  <= act_ctr ? !top_hit : 1'b1;
      end
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_pair
    logic [CW-1:0] v_even, v_odd;
    logic          ge_even, ge_odd;
    logic [DW-1:0] dtc;

    assign v_even  = act_val[(2*p)*CW +: CW];
    assign v_odd   = act_val[(2*p+1)*CW +: CW];
    assign ge_even = cnt >= v_even;
    assign ge_odd  = cnt >= v_odd;
    assign raw_c[p] = act_ctr ? ((act_asym[p] && !up) ? ge_odd : ge_even)
                              : (act_asym[p] ? (ge_even ^ ge_odd) : ge_even);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_q[p] <= 1'b0;
        dtc      <= '0;
      end else if (!run) begin
        raw_q[p] <= 1'b0;
        dtc      <= '0;
      end else begin
        raw_q[p] <= raw_c[p];
        if (raw_c[p] != raw_q[p]) dtc <= dead_in;
        else if (dtc != '0)       dtc <= dtc - 1'b1;
      end
    end

    assign pwm_out[2*p]   = run_q &&  raw_q[p] && (dtc == '0);
    assign pwm_out[2*p+1] = run_q && !raw_q[p] && (dtc == '0);
  end

  assign reload_out = reload_q;

endmodule

module pwm_phase_gen_chk #(
  parameter int CW = 12,
  parameter int DW = 4,
  parameter int NP = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic [DW-1:0]   dead_in,
  input logic [2*NP-1:0] pwm_out,
  input logic            reload_out,
  input logic [CW-1:0]   cnt,
  input logic [CW-1:0]   act_mod
);

  logic [NP-1:0] both_on;
  always_comb begin
    for (int p = 0; p < NP; p++) both_on[p] = pwm_out[2*p] && pwm_out[2*p+1];
  end

  assert_pair_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    both_on == '0);

  assert_reload_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_out && act_mod >= CW'(2)) |=> !reload_out);

  assert_reload_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reload_out |-> cnt == '0);

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act_mod || cnt == '0);

  assert_stop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pwm_out == '0 && !reload_out));

  for (genvar p = 0; p < NP; p++) begin : g_dead
    assert_dead_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwm_out[2*p]) && $past(dead_in) != '0) |-> !$past(pwm_out[2*p+1]));
  end

endmodule

bind pwm_phase_gen pwm_phase_gen_chk #(.CW(CW), .DW(DW), .NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .dead_in(dead_in), .pwm_out(pwm_out),
  .reload_out(reload_out), .cnt(cnt), .act_mod(act_mod)
);

// File: tb/sim_pwm_phase_gen.sv
module sim_pwm_phase_gen;
  localparam int CW = 12;
  localparam int DW = 4;
  localparam int NP = 3;
  localparam int NC = 2 * NP;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic             center_in = 1'b0;
  logic [NP-1:0]    asym_in = '0;
  logic [CW-1:0]    mod_in = CW'(20);
  logic [NC*CW-1:0] val_in = '0;
  logic [DW-1:0]    dead_in = '0;
  logic [NC-1:0]    pwm_out;
  logic             reload_out;

  pwm_phase_gen #(.CW(CW), .DW(DW), .NP(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .center_in(center_in), .asym_in(asym_in),
    .mod_in(mod_in), .val_in(val_in), .dead_in(dead_in), .pwm_out(pwm_out),
    .reload_out(reload_out)
  );

  always #2 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string tag = "R1";

  int mpos, mm, mc, ma, mrel, mrunq;
  int mv [NC];
  int mraw [NP];
  int mdt [NP];

  task automatic set_vals(input int a, input int b, input int c,
                          input int d, input int e, input int f);
    int t [NC];
    t = '{a, b, c, d, e, f};
    for (int k = 0; k < NC; k++) val_in[k*CW +: CW] = CW'(t[k]);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpos = 0; mm = 0; mc = 0; ma = 0; mrel = 0; mrunq = 0;
      for (int k = 0; k < NC; k++) mv[k] = 0;
      for (int p = 0; p < NP; p++) begin mraw[p] = 0; mdt[p] = 0; end
    end else if (!run) begin
      mpos = 0; mm = int'(mod_in); mc = int'(center_in); ma = int'(asym_in);
      for (int k = 0; k < NC; k++) mv[k] = int'(val_in[k*CW +: CW]);
      for (int p = 0; p < NP; p++) begin mraw[p] = 0; mdt[p] = 0; end
      mrel = 0; mrunq = 0;
    end else begin
      int c, len;
      bit upf;
      c   = (mc != 0) ? ((mpos <= mm) ? mpos : 2*mm - mpos) : mpos;
      upf = (mc != 0) ? (mpos < mm) : 1'b1;
      for (int p = 0; p < NP; p++) begin
        bit a, b, r, asy;
        a = c >= mv[2*p];
        b = c >= mv[2*p+1];
        asy = ma[p];
        if (mc != 0) r = (asy && !upf) ? b : a;
        else         r = asy ? (a ^ b) : a;
        if (int'(r) != mraw[p]) mdt[p] = int'(dead_in);
        else if (mdt[p] > 0)    mdt[p] = mdt[p] - 1;
        mraw[p] = int'(r);
      end
      len = (mc != 0) ? 2*mm : mm;
      if (mpos + 1 >= len) begin
        mpos = 0; mm = int'(mod_in); mc = int'(center_in); ma = int'(asym_in);
        for (int k = 0; k < NC; k++) mv[k] = int'(val_in[k*CW +: CW]);
        mrel = 1;
      end else begin
        mpos = mpos + 1;
        mrel = 0;
      end
      mrunq = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [NC-1:0] ep;
      for (int p = 0; p < NP; p++) begin
        ep[2*p]   = (mrunq != 0) && (mraw[p] != 0) && (mdt[p] == 0);
        ep[2*p+1] = (mrunq != 0) && (mraw[p] == 0) && (mdt[p] == 0);
      end
      n_cmp++;
      if (pwm_out !== ep || reload_out !== (mrel != 0)) begin
        n_bad++;
        $display("FAIL %s cycle %0d: pwm=%b reload=%b expected pwm=%b reload=%b",
                 tag, cycles, pwm_out, reload_out, ep, mrel != 0);
      end
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_bad++;
        $display("FAIL watchdog (all requirements): run did not end, got %0d cycles expected fewer", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    wait_cycles(4);
    n_cmp++;
    if (pwm_out !== '0) begin
      n_bad++;
      $display("FAIL R1 reset pwm=%b expected %b", pwm_out, {NC{1'b0}});
    end
    n_cmp++;
    if (reload_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset reload=%b expected 0", reload_out);
    end
    rst_n = 1'b1;
    tag = "R2 idle";
    wait_cycles(3);

    tag = "R3 R5 R8 R11 edge";
    center_in = 0; asym_in = 3'b000; mod_in = CW'(20); dead_in = '0;
    set_vals(5, 0, 10, 0, 15, 0);
    run = 1'b1;
    wait_cycles(65);

    tag = "R2 stop";
    run = 1'b0;
    dead_in = DW'(3);
    wait_cycles(4);

    tag = "R9 deadtime";
    run = 1'b1;
    wait_cycles(65);

    tag = "R10 shadow edge";
    wait_cycles(7);
    mod_in = CW'(24);
    set_vals(0, 0, 12, 0, 23, 0);
    wait_cycles(80);

    tag = "R7 R11 edge asym";
    asym_in = 3'b010;
    set_vals(3, 17, 4, 12, 8, 2);
    wait_cycles(90);

    tag = "R2 stop";
    run = 1'b0;
    dead_in = DW'(2);
    wait_cycles(5);

    tag = "R4 R6 center asym";
    center_in = 1'b1; asym_in = 3'b101; mod_in = CW'(16);
    set_vals(4, 12, 6, 6, 10, 3);
    run = 1'b1;
    wait_cycles(110);

    tag = "R10 shadow mode";
    wait_cycles(5);
    center_in = 1'b0; asym_in = 3'b111; mod_in = CW'(18);
    set_vals(0, 9, 2, 16, 5, 5);
    wait_cycles(90);

    tag = "R2 stop";
    run = 1'b0;
    dead_in = DW'(4);
    wait_cycles(5);

    tag = "R7 shifted edge pulses";
    center_in = 1'b0; asym_in = 3'b111; mod_in = CW'(3200);
    set_vals(800, 1600, 1600, 2400, 2400, 800);
    run = 1'b1;
    wait_cycles(6500);

    tag = "R2 stop";
    run = 1'b0;
    wait_cycles(5);

    tag = "R6 shifted center pulses";
    center_in = 1'b1; asym_in = 3'b011; mod_in = CW'(3200);
    set_vals(800, 2400, 2400, 800, 1600, 0);
    run = 1'b1;
    wait_cycles(13000);

    tag = "R2 stop";
    run = 1'b0;
    wait_cycles(6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule